// File: doc/BRIEF.md
# Interrupt State, Enable and Test Registers

This block keeps a parameterised set of interrupt bits behind three word-indexed registers on a simple register bus. Hardware event pulses latch into a state register. Software acknowledges an interrupt by writing ones to the state register, which clears those bits. An enable register selects which latched bits may drive their interrupt output lines. Each output line is registered.

A write-only test register lets software force state bits to one, so the full interrupt path can be exercised without the real event source. Every write to it also produces a one-cycle qualifier strobe, along with the written bits, for any logic that needs to see the injection.

The interrupt bits are grouped into entries of equal width. The entries are packed from bit 0 upward, and all unused upper bits of the register word are inert.

Top module: `irq_trio_regs`

## Requirements
- R1: With the default `BaseIdx` of 4, the state register is at word index BaseIdx, the enable register at BaseIdx+1 and the test register at BaseIdx+2.
- R2: A high bit on `hwEvent` in a cycle sets the matching state bit at that clock edge. The bit reads back as 1 from the following cycle.
- R3: Writing the state register clears every state bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If a hardware event and a software clear hit the same state bit in one cycle, the bit ends up set.
- R5: The enable register reads back what was last written to it. `irqOut[i]` is the AND of state bit i and enable bit i, registered, so it follows a change of either one cycle later.
- R6: Writing 1 to a bit of the test register sets the matching state bit at that edge. Reading the test register returns 0.
- R7: Every write to the test register raises `testQe` for exactly the one cycle after the write edge. During that cycle `testQ` holds the written interrupt bits.
- R8: After reset, the state and enable registers read 0, `irqOut` is 0 and `testQe` is 0.
- R9: A read of any word index other than the three mapped ones returns 0. A write to such an index changes no state, no enable bit and no output.
- R10: Entry e covers bits e*EntryWidth to e*EntryWidth+EntryWidth-1. Register bits at or above NumEntries*EntryWidth (6 by default) always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | AddrWidth | Word index of the access |
| regWe | input | 1 | Write request, one cycle per write |
| regWdata | input | RegWidth | Write data |
| regRdata | output | RegWidth | Read data for `regAddr`, combinational |
| hwEvent | input | NumEntries*EntryWidth | Hardware event pulses, one per interrupt bit |
| irqOut | output | NumEntries*EntryWidth | Registered interrupt lines |
| testQe | output | 1 | One-cycle strobe after a test register write |
| testQ | output | NumEntries*EntryWidth | Interrupt bits of the last test register write |

## Verification
A state bit that is corrupted internally shows up on the read-back of the state word in the very next cycle. Its effect on `irqOut` appears one cycle after that, and only if the bit is enabled. An error in address decode reaches the ports in the same cycle as the access, as read data returned from the wrong register. It also shows as a side effect one cycle later, such as a changed enable word or a stray `testQe` pulse. A lost event when a set and a clear collide leaves the state word reading 0 on the cycle after the collision, where 1 is expected.

// File: rtl/irq_trio_pkg.sv
package irq_trio_pkg;

  typedef struct packed {
    logic stateWe;
    logic enableWe;
    logic testWe;
  } irqStrobes_t;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATE  = 2'd1,
    RD_ENABLE = 2'd2
  } irqRdSel_e;

  localparam int unsigned OFS_STATE  = 0;
  localparam int unsigned OFS_ENABLE = 1;
  localparam int unsigned OFS_TEST   = 2;

endpackage

// File: rtl/irq_trio_ctrl.sv
module irq_trio_ctrl
  import irq_trio_pkg::*;
#(
  parameter int unsigned AddrWidth = 4,
  parameter int unsigned BaseIdx   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [AddrWidth-1:0] regAddr,
  input  logic                 regWe,
  output irqStrobes_t          strobes,
  output irqRdSel_e            rdSel
);

  localparam logic [AddrWidth-1:0] StateIdx  = AddrWidth'(BaseIdx + OFS_STATE);
  localparam logic [AddrWidth-1:0] EnableIdx = AddrWidth'(BaseIdx + OFS_ENABLE);
  localparam logic [AddrWidth-1:0] TestIdx   = AddrWidth'(BaseIdx + OFS_TEST);

  logic hitState, hitEnable, hitTest;

  always_comb begin
    hitState  = (regAddr == StateIdx);
    hitEnable = (regAddr == EnableIdx);
    hitTest   = (regAddr == TestIdx);

    strobes.stateWe  = regWe && hitState;
    strobes.enableWe = regWe && hitEnable;
    strobes.testWe   = regWe && hitTest;

    if (hitState)       rdSel = RD_STATE;
    else if (hitEnable) rdSel = RD_ENABLE;
    else                rdSel = RD_NONE;
  end

  // R1: at most one register is written per access
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.stateWe, strobes.enableWe, strobes.testWe}));

endmodule

// File: rtl/irq_trio_dp.sv
module irq_trio_dp
  import irq_trio_pkg::*;
#(
  parameter int unsigned RegWidth   = 32,
  parameter int unsigned NumEntries = 3,
  parameter int unsigned EntryWidth = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  irqStrobes_t                         strobes,
  input  irqRdSel_e                           rdSel,
  input  logic [RegWidth-1:0]                 regWdata,
  input  logic [NumEntries*EntryWidth-1:0]    hwEvent,
  output logic [RegWidth-1:0]                 regRdata,
  output logic [NumEntries*EntryWidth-1:0]    irqOut,
  output logic                                testQe,
  output logic [NumEntries*EntryWidth-1:0]    testQ
);

  localparam int unsigned NumIrq = NumEntries * EntryWidth;

  logic [NumIrq-1:0] stateQ, enableQ;
  logic [NumIrq-1:0] wdataM, clrMask, setMask;

  initial begin
    if (NumIrq > RegWidth) $error("interrupt bits exceed register width");
  end

  always_comb begin
    wdataM  = regWdata[NumIrq-1:0];
    clrMask = strobes.stateWe ? wdataM : '0;
    setMask = hwEvent | (strobes.testWe ? wdataM : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= '0;
      enableQ <= '0;
      testQe  <= 1'b0;
      testQ   <= '0;
    end else begin
      stateQ <= (stateQ & ~clrMask) | setMask;
      if (strobes.enableWe) enableQ <= wdataM;
      testQe <= strobes.testWe;
      if (strobes.testWe) testQ <= wdataM;
    end
  end

  for (genvar e = 0; e < NumEntries; e++) begin : gEntry
    localparam int unsigned Lo = e * EntryWidth;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqOut[Lo +: EntryWidth] <= '0;
      else       irqOut[Lo +: EntryWidth] <= stateQ[Lo +: EntryWidth] & enableQ[Lo +: EntryWidth];
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (rdSel)
      RD_STATE:  regRdata[NumIrq-1:0] = stateQ;
      RD_ENABLE: regRdata[NumIrq-1:0] = enableQ;
      default:   regRdata = '0;
    endcase
  end

  // R2 / R4: an event is never lost, even against a clear
  a_r4_event_kept: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((($past(hwEvent) & ~stateQ)) == '0));

  // R3: cleared bits without a concurrent set read 0
  a_r3_clear_done: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobes.stateWe) && !$past(strobes.testWe)) |->
      ((stateQ & $past(wdataM & ~hwEvent)) == '0));

  // R5: no line is raised without its enable bit
  a_r5_masked: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((irqOut & ~$past(enableQ)) == '0));

endmodule

// File: rtl/irq_trio_regs.sv
module irq_trio_regs
  import irq_trio_pkg::*;
#(
  parameter int unsigned RegWidth   = 32,
  parameter int unsigned AddrWidth  = 4,
  parameter int unsigned BaseIdx    = 4,
  parameter int unsigned NumEntries = 3,
  parameter int unsigned EntryWidth = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [AddrWidth-1:0]             regAddr,
  input  logic                             regWe,
  input  logic [RegWidth-1:0]              regWdata,
  output logic [RegWidth-1:0]              regRdata,
  input  logic [NumEntries*EntryWidth-1:0] hwEvent,
  output logic [NumEntries*EntryWidth-1:0] irqOut,
  output logic                             testQe,
  output logic [NumEntries*EntryWidth-1:0] testQ
);

  irqStrobes_t strobes;
  irqRdSel_e   rdSel;

  irq_trio_ctrl #(.AddrWidth(AddrWidth), .BaseIdx(BaseIdx)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .strobes(strobes), .rdSel(rdSel)
  );

  irq_trio_dp #(.RegWidth(RegWidth), .NumEntries(NumEntries), .EntryWidth(EntryWidth)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSel(rdSel),
    .regWdata(regWdata), .hwEvent(hwEvent), .regRdata(regRdata),
    .irqOut(irqOut), .testQe(testQe), .testQ(testQ)
  );

  // R7: the qualifier follows a test-register write at the ports
  a_r7_test_strobe: assert property (@(posedge clk) disable iff (!rstN)
    testQe |-> ($past(rstN) && $past(regWe) &&
                ($past(regAddr) == AddrWidth'(BaseIdx + OFS_TEST))));

endmodule

// File: tb/sim_irq_trio_regs.sv
module sim_irq_trio_regs;
  localparam int ClkPeriod = 10;
  localparam int NI = 6;
  localparam logic [3:0] A_ST = 4'd4, A_EN = 4'd5, A_TS = 4'd6;

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic [NI-1:0] hwEvent = '0, irqOut, testQ;
  logic testQe;
  int nChk = 0, nBad = 0;

  always #(ClkPeriod/2) clk = ~clk;

  irq_trio_regs u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .hwEvent(hwEvent),
    .irqOut(irqOut), .testQe(testQe), .testQ(testQ)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, one edge, return at next negedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [NI-1:0] ev = '0);
    regAddr = a; regWdata = d; regWe = 1'b1; hwEvent = ev;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0; hwEvent = '0;
  endtask

  task automatic pulse(input logic [NI-1:0] ev);
    hwEvent = ev;
    @(negedge clk);
    hwEvent = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_ST, d); chk("R8 state", d, 0);
    rd(A_EN, d); chk("R8 enable", d, 0);
    chk("R8 irqOut", 32'(irqOut), 0);
    chk("R8 testQe", 32'(testQe), 0);
  endtask

  task automatic t_event_clear;
    logic [31:0] d;
    pulse(6'b000101);
    rd(A_ST, d); chk("R2 event sets", d, 32'h5);
    wr(A_ST, 32'h0000_0001);
    rd(A_ST, d); chk("R3 w1c", d, 32'h4);
    wr(A_ST, 32'h0);
    rd(A_ST, d); chk("R3 zero keeps", d, 32'h4);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    wr(A_ST, 32'h4, 6'b000100);
    rd(A_ST, d); chk("R4 set wins", d, 32'h4);
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, d); chk("R3 clear all", d, 32'h0);
  endtask

  task automatic t_enable_irq;
    logic [31:0] d;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); chk("R10 enable upper bits", d, 32'h3F);
    wr(A_EN, 32'h0000_0003);
    rd(A_EN, d); chk("R5 enable readback", d, 32'h3);
    pulse(6'b000010);
    chk("R5 irq lags", 32'(irqOut), 0);
    @(negedge clk);
    chk("R5 irq raised", 32'(irqOut), 32'h2);
    wr(A_EN, 32'h1);
    chk("R5 irq still up", 32'(irqOut), 32'h2);
    @(negedge clk);
    chk("R5 irq masked", 32'(irqOut), 32'h0);
  endtask

  task automatic t_test_reg;
    logic [31:0] d;
    wr(A_TS, 32'h30);
    chk("R7 testQe high", 32'(testQe), 1);
    chk("R7 testQ", 32'(testQ), 32'h30);
    rd(A_ST, d); chk("R6 test sets", d, 32'h32);
    rd(A_TS, d); chk("R6 test reads 0", d, 0);
    @(negedge clk);
    chk("R7 testQe one cycle", 32'(testQe), 0);
    wr(A_ST, 32'h3F);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(A_EN, 32'h3);
    wr(4'd7, 32'hFFFF_FFFF);
    chk("R9 no strobe", 32'(testQe), 0);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd7, d); chk("R9 read unmapped", d, 0);
    rd(4'd0, d); chk("R1 base-relative decode", d, 0);
    rd(A_ST, d); chk("R9 state untouched", d, 0);
    rd(A_EN, d); chk("R9 enable untouched", d, 32'h3);
  endtask

  task automatic t_upper_bits;
    logic [31:0] d;
    wr(A_TS, 32'hFFFF_FFC0);
    chk("R10 testQ masked", 32'(testQ), 0);
    rd(A_ST, d); chk("R10 upper test ignored", d, 0);
    pulse(6'b110000);
    rd(A_ST, d); chk("R10 entry 2 packing", d, 32'h30);
    wr(A_EN, 32'h30);
    @(negedge clk);
    chk("R10 entry 2 irq", 32'(irqOut), 32'h30);
  endtask

  initial begin
    #(ClkPeriod * 20000);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_event_clear();
    t_set_wins();
    t_enable_irq();
    t_test_reg();
    t_unmapped();
    t_upper_bits();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule